// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds a set of identical 32-bit timer channels behind a word-addressed register port. Each channel has three registers: a control word, a load value and a live count. Software writes the load value first. It then writes the control word with the run bit set. The channel restarts from the load value and steps once on every pulse of the shared `tick` strobe. The direction bit selects whether it counts up or down.

A channel expires when a tick arrives while the count sits at its terminal value. The terminal value is zero when counting down and all-ones when counting up. On expiry the channel raises its pending flag. With auto-reload set, it reloads from the load value and keeps running. Without auto-reload, it halts and holds the terminal value. Each pending flag is masked by its channel's interrupt-enable bit, and the masked flags are ORed onto one interrupt line. Software acknowledges an interrupt by rewriting the control word.

Top module: `tmr_bank`

## Requirements
- R1: After reset every control, load and count register of every channel reads 0 and `irq` is low.
- R2: Address decode works as follows. Word-address bits [1:0] select the register: 0 is control, 1 is load, 2 is count. The bits above them select the channel. Register word 3 reads 0 and ignores writes. An access to a channel index at or above NUM_CH reads 0 and changes no channel.
- R3: The control word keeps its low 11 bits and reads bits 31..11 as 0. Bits 0, 2, 3, 5, 9 and 10 are stored and read back but have no effect on counting.
- R4: A control write with bit 7 (run) set loads the count from the load register. A write to the load register alone leaves the count unchanged. Writes to the count register are ignored.
- R5: With control bit 1 = 1 a running channel decrements by one per tick. A tick while the count is 0 is an expiry.
- R6: With control bit 1 = 0 a running channel increments by one per tick. A tick while the count is all-ones is an expiry.
- R7: An expiry sets control bit 8 (pending). If control bit 4 (auto-reload) is set, the count is reloaded from the load register and counting continues.
- R8: After an expiry without auto-reload, the count holds the terminal value through further ticks until a control write with bit 7 set.
- R9: With bit 7 clear the count does not change on ticks. A control write with bit 7 clear does not restart the count.
- R10: Any control write stores bit 8 as 0, whatever value is written to that bit. If an expiry occurs in the same cycle, the write takes priority.
- R11: `irq` is high exactly when some channel has both bit 8 (pending) and bit 6 (interrupt enable) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe shared by all channels |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address: channel index above, register select in bits [1:0] |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` (combinational) |
| irq | output | 1 | Combined, enable-masked interrupt |

## Verification
The hardest event to reach from the ports is the up-count expiry. From a small load value it needs about 2^32 ticks. The bench reaches it by loading a value just below all-ones, so that the wrap and the auto-reload happen within a few ticks, and then repeats the period to confirm it runs again. A second case is the masked interrupt. A pending flag with its enable clear must leave `irq` low, and the only way to create such a flag is a real expiry on a channel configured without the enable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CSR_W    = 11;
  localparam int B_DOWN   = 1;
  localparam int B_RELOAD = 4;
  localparam int B_IE     = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;

  localparam logic [1:0] SEL_CSR   = 2'd0;
  localparam logic [1:0] SEL_LOAD  = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;

  typedef struct packed {
    logic csrWr;
    logic loadWr;
  } chStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CSR_W-1:0]  csrQ   [NUM_CH],
  input  logic [DATA_W-1:0] loadQ  [NUM_CH],
  input  logic [DATA_W-1:0] countQ [NUM_CH],
  output chStrobe_t         strobe [NUM_CH],
  output logic [DATA_W-1:0] rdData
);
  localparam int CH_W = ADDR_W - 2;

  logic [CH_W-1:0]     chIdx;
  logic [1:0]          regSel;
  logic [2*NUM_CH-1:0] strobeBits;

  assign chIdx  = addr[ADDR_W-1:2];
  assign regSel = addr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    assign hit              = wrEn && (chIdx == CH_W'(i));
    assign strobe[i].csrWr  = hit && (regSel == SEL_CSR);
    assign strobe[i].loadWr = hit && (regSel == SEL_LOAD);
    assign strobeBits[2*i]   = strobe[i].csrWr;
    assign strobeBits[2*i+1] = strobe[i].loadWr;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chIdx == CH_W'(i)) begin
        case (regSel)
          SEL_CSR:   rdData = DATA_W'(csrQ[i]);
          SEL_LOAD:  rdData = loadQ[i];
          SEL_COUNT: rdData = countQ[i];
          default:   rdData = '0;
        endcase
      end
    end
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeBits));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [DATA_W-1:0] wrData,
  input  chStrobe_t         strobe [NUM_CH],
  output logic [CSR_W-1:0]  csrQ   [NUM_CH],
  output logic [DATA_W-1:0] loadQ  [NUM_CH],
  output logic [DATA_W-1:0] countQ [NUM_CH],
  output logic              irq
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic halted;
    logic running;
    logic atEnd;
    logic expire;

    assign running = csrQ[i][B_RUN] && !halted;
    assign atEnd   = csrQ[i][B_DOWN] ? (countQ[i] == '0) : (&countQ[i]);
    assign expire  = running && tick && atEnd;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        csrQ[i]   <= '0;
        countQ[i] <= '0;
        halted    <= 1'b0;
      end else if (strobe[i].csrWr) begin
        csrQ[i] <= {wrData[CSR_W-1:B_FLAG+1], 1'b0, wrData[B_FLAG-1:0]};
        halted  <= 1'b0;
        if (wrData[B_RUN]) countQ[i] <= loadQ[i];
      end else if (expire) begin
        csrQ[i][B_FLAG] <= 1'b1;
        if (csrQ[i][B_RELOAD]) countQ[i] <= loadQ[i];
        else                   halted    <= 1'b1;
      end else if (running && tick) begin
        countQ[i] <= csrQ[i][B_DOWN] ? countQ[i] - DATA_W'(1)
                                     : countQ[i] + DATA_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                 loadQ[i] <= '0;
      else if (strobe[i].loadWr) loadQ[i] <= wrData;
    end

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].csrWr |=> !csrQ[i][B_FLAG]);
    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].csrWr && wrData[B_RUN]) |=> (countQ[i] == $past(loadQ[i])));
    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe[i].csrWr && !csrQ[i][B_RUN]) |=> $stable(countQ[i]));
    // R7
    flag_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(csrQ[i][B_FLAG]) |-> $past(tick));
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      irq = irq | (csrQ[i][B_FLAG] & csrQ[i][B_IE]);
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  chStrobe_t         strobe [NUM_CH];
  logic [CSR_W-1:0]  csrQ   [NUM_CH];
  logic [DATA_W-1:0] loadQ  [NUM_CH];
  logic [DATA_W-1:0] countQ [NUM_CH];

  tmr_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .csrQ(csrQ), .loadQ(loadQ), .countQ(countQ),
    .strobe(strobe), .rdData(rdData)
  );

  tmr_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wrData(wrData),
    .strobe(strobe), .csrQ(csrQ), .loadQ(loadQ), .countQ(countQ),
    .irq(irq)
  );
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  tmr_bank dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    addr = 6'(ch * 4 + sel); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input int ch, input int sel, input logic [31:0] exp);
    addr = 6'(ch * 4 + sel);
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    rdChk("R1 csr0", 0, 0, 32'h0);
    rdChk("R1 load1", 1, 1, 32'h0);
    rdChk("R1 count2", 2, 2, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_down_oneshot;
    wr(0, 1, 32'd3);
    wr(0, 0, 32'h0C2);
    rdChk("R4 restart count", 0, 2, 32'd3);
    ticks(3);
    rdChk("R5 count at zero", 0, 2, 32'd0);
    rdChk("R5 no flag yet", 0, 0, 32'h0C2);
    ticks(1);
    rdChk("R7 flag set", 0, 0, 32'h1C2);
    chk("R11 irq on", {31'b0, irq}, 32'h1);
    ticks(2);
    rdChk("R8 holds terminal", 0, 2, 32'd0);
  endtask

  task automatic t_clear;
    wr(0, 0, 32'h142);
    rdChk("R10 flag stored 0", 0, 0, 32'h042);
    chk("R11 irq off", {31'b0, irq}, 32'h0);
    rdChk("R9 no restart", 0, 2, 32'd0);
  endtask

  task automatic t_up_reload;
    wr(1, 1, 32'hFFFF_FFFD);
    wr(1, 0, 32'h0D0);
    ticks(2);
    rdChk("R6 up to all-ones", 1, 2, 32'hFFFF_FFFF);
    rdChk("R6 no flag yet", 1, 0, 32'h0D0);
    ticks(1);
    rdChk("R7 reload", 1, 2, 32'hFFFF_FFFD);
    rdChk("R7 flag up", 1, 0, 32'h1D0);
    chk("R11 irq up", {31'b0, irq}, 32'h1);
    wr(1, 0, 32'h1D0);
    ticks(3);
    rdChk("R7 second period", 1, 0, 32'h1D0);
    rdChk("R7 second reload", 1, 2, 32'hFFFF_FFFD);
    wr(1, 0, 32'h0);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_freeze;
    wr(2, 1, 32'd10);
    wr(2, 0, 32'h082);
    ticks(2);
    rdChk("R5 decrement", 2, 2, 32'd8);
    wr(2, 0, 32'h002);
    ticks(3);
    rdChk("R9 frozen", 2, 2, 32'd8);
    wr(2, 1, 32'd50);
    rdChk("R4 load no effect", 2, 2, 32'd8);
    rdChk("R4 load stored", 2, 1, 32'd50);
    wr(2, 2, 32'h1234);
    rdChk("R4 count write ignored", 2, 2, 32'd8);
    wr(2, 0, 32'h082);
    rdChk("R4 restart new load", 2, 2, 32'd50);
    wr(2, 0, 32'h0);
  endtask

  task automatic t_gate;
    wr(3, 1, 32'd0);
    wr(3, 0, 32'h082);
    ticks(1);
    rdChk("R11 masked flag set", 3, 0, 32'h182);
    chk("R11 masked irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(0, 3, 32'hFFFF);
    rdChk("R2 word3 reads 0", 0, 3, 32'h0);
    rdChk("R2 word3 no side effect", 0, 0, 32'h042);
    wr(4, 0, 32'h1FF);
    rdChk("R2 bad channel reads 0", 4, 0, 32'h0);
    rdChk("R2 bad channel no alias", 0, 0, 32'h042);
    rdChk("R2 bad channel load", 4, 1, 32'h0);
  endtask

  task automatic t_spare;
    wr(3, 0, 32'hFFFF_F62D);
    rdChk("R3 spare bits readback", 3, 0, 32'h0000_062D);
    ticks(2);
    rdChk("R3 spare bits no effect", 3, 2, 32'd0);
    chk("R3 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_down_oneshot();
    t_clear();
    t_up_reload();
    t_freeze();
    t_gate();
    t_map();
    t_spare();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule